// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command packets kept in a word-addressed memory. Each node starts with a header word. Its top byte gives the number of payload words that follow the header, and its low 24 bits give the byte address of the next node. The walker forwards each payload word to a command sink over a valid/ready handshake. It then moves on to the next node. It keeps a running cost figure for the walk as it goes.

A walk begins on a start pulse and ends for one of three reasons. The current address may carry the end marker. The chain may be found to close on itself; this is caught with a checkpoint address that is re-anchored at doubling node counts, so a loop that does not pass through the start node is still caught. In budget mode, the cost may grow past a fixed threshold. When the walk ends, the walker raises done and holds the final address and the total cost until the next start. The payload words are not interpreted.

Top module: `dma_chain_walker`

## Requirements
- R1: A header word is split into a length (bits 31:24, in words) and a next-node address (bits 23:0). The payload words sit at the word indices directly after the header, and they are forwarded in increasing index order.
- R2: The memory word index is address bits 20:2, so address bits 22:21 and 1:0 do not select a word. Read data is taken in the cycle after mem_rd_o is high. mem_rd_o is never high while cmd_valid_o is high.
- R3: A walk ends as soon as the current address has bit 23 set. This includes a start address with bit 23 set, which reads no memory and costs 0. final_addr_o then equals that address.
- R4: A node with length 0 forwards no payload words, and the walk still continues to its next-node address.
- R5: Each visited node adds 10 to the cost. A node with a nonzero length adds a further 5 plus its length. The cost never decreases during a walk.
- R6: A checkpoint starts at the start address, and a limit starts at 32. After each node, the walk ends if the next address equals the checkpoint. Otherwise, if the count of nodes already passed equals the limit, the checkpoint takes the next address and the limit doubles; the count then increments.
- R7: In budget mode, after each node's cost has been added (plus 5 more when the double-height input is set), the walk ends if the cost exceeds 512. This is checked before the checkpoint test. Outside budget mode, the double-height input adds nothing.
- R8: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o stays high and cmd_data_o stays unchanged.
- R9: start_i is taken only while busy_o is low. The address and mode inputs are captured then. When done_o is high, final_addr_o and cycles_o stay stable until the next start.
- R10: After reset, busy_o, done_o, cmd_valid_o and mem_rd_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk (ignored while busy) |
| start_addr_i | input | 24 | Byte address of the first node |
| budget_en_i | input | 1 | Enable the cost budget stop |
| dbl_height_i | input | 1 | Adds 5 per node in budget mode |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished, results valid |
| final_addr_o | output | 24 | Address at which the walk stopped |
| cycles_o | output | 32 | Accumulated cost |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_idx_o | output | 19 | Memory word index |
| mem_rdata_i | input | 32 | Read data, one cycle after the strobe |
| cmd_valid_o | output | 1 | Payload word valid |
| cmd_data_o | output | 32 | Payload word |
| cmd_ready_i | input | 1 | Sink accepts the word |

## Verification
Several properties are checked on every cycle. A stalled payload word must hold steady. Results must stay frozen while done is high. Busy and done must never be high together. A read strobe must never coincide with a valid payload. A start taken while idle must raise busy, and the cost must only grow within a walk. Other behaviours can only be shown by the bench's scenarios, checked against a reference walk. These are the payload order, the cost arithmetic, the end-marker stop, checkpoint re-anchoring for loops that miss the start node, the budget cut-off with and without double height, address aliasing, and a start that is ignored in the middle of a walk.

// File: rtl/dcw_pkg.sv
package dcw_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HREQ,
    ST_HDAT,
    ST_PREQ,
    ST_PDAT,
    ST_PSEND,
    ST_LINK,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/dcw_cost_acc.sv
module dcw_cost_acc #(
  parameter int CW        = 32,
  parameter int LW        = 8,
  parameter int NODE_COST = 10,
  parameter int PAY_COST  = 5,
  parameter int DBL_COST  = 5,
  parameter int BUDGET    = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          hdr_i,
  input  logic [LW-1:0] len_i,
  input  logic          link_i,
  input  logic          extra_en_i,
  output logic [CW-1:0] cyc_o,
  output logic          over_o
);
  localparam logic [CW-1:0] K_NODE = CW'(NODE_COST);
  localparam logic [CW-1:0] K_PAY  = CW'(PAY_COST);
  localparam logic [CW-1:0] K_DBL  = CW'(DBL_COST);
  localparam logic [CW-1:0] K_BUD  = CW'(BUDGET);

  logic [CW-1:0] cyc_q, cyc_d, add;
  logic          cyc_en;
  logic [CW-1:0] link_sum;

  always_comb begin
    add = '0;
    if (hdr_i) begin
      add = K_NODE;
      if (len_i != '0) add = K_NODE + K_PAY + CW'(len_i);
    end else if (link_i && extra_en_i) begin
      add = K_DBL;
    end
    cyc_en = init_i | hdr_i | (link_i & extra_en_i);
    cyc_d  = init_i ? '0 : (cyc_q + add);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cyc_q <= '0;
    else if (cyc_en) cyc_q <= cyc_d;
  end

  assign link_sum = cyc_q + (extra_en_i ? K_DBL : '0);
  assign over_o   = link_sum > K_BUD;
  assign cyc_o    = cyc_q;
endmodule

// File: rtl/dcw_loop_guard.sv
module dcw_loop_guard #(
  parameter int AW       = 24,
  parameter int NW       = 32,
  parameter int LIM_INIT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic [AW-1:0] init_addr_i,
  input  logic          step_i,
  input  logic [AW-1:0] nxt_i,
  output logic          hit_o
);
  logic [AW-1:0] ck_q, ck_d;
  logic [NW-1:0] lim_q, lim_d, cnt_q, cnt_d;
  logic          en, reanchor;

  always_comb begin
    reanchor = step_i && (cnt_q == lim_q);
    en       = init_i | step_i;
    ck_d     = ck_q;
    lim_d    = lim_q;
    cnt_d    = cnt_q;
    if (init_i) begin
      ck_d  = init_addr_i;
      lim_d = NW'(LIM_INIT);
      cnt_d = '0;
    end else if (step_i) begin
      if (reanchor) begin
        ck_d  = nxt_i;
        lim_d = lim_q << 1;
      end
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q  <= '0;
      lim_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      ck_q  <= ck_d;
      lim_q <= lim_d;
      cnt_q <= cnt_d;
    end
  end

  assign hit_o = (nxt_i == ck_q);
endmodule

// File: rtl/dcw_walk_ctrl.sv
module dcw_walk_ctrl
  import dcw_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int LW = 8,
  parameter int MB = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          budget_en_i,
  input  logic          dbl_height_i,
  input  logic          over_i,
  input  logic          hit_i,
  output logic          mem_rd_o,
  output logic [MB-3:0] mem_idx_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          cmd_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] cur_o,
  output logic          init_o,
  output logic          hdr_o,
  output logic [LW-1:0] len_o,
  output logic          link_o,
  output logic          step_o,
  output logic          extra_en_o,
  output logic [AW-1:0] nxt_o
);
  localparam int IW      = MB - 2;
  localparam int END_BIT = AW - 1;

  walk_state_e   state_q, state_d;
  logic [AW-1:0] cur_q, cur_d, nxt_q, nxt_d;
  logic [IW-1:0] ptr_q, ptr_d;
  logic [LW-1:0] rem_q, rem_d;
  logic [DW-1:0] data_q, data_d;
  logic          ben_q, dbl_q, mode_en;
  logic          cur_en, nxt_en, ptr_en, rem_en, data_en;
  logic          idle_like, stop;

  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign init_o    = start_i && idle_like;
  assign stop      = (ben_q && over_i) || hit_i;
  assign len_o     = mem_rdata_i[DW-1 -: LW];

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    nxt_d   = nxt_q;
    ptr_d   = ptr_q;
    rem_d   = rem_q;
    data_d  = mem_rdata_i;
    cur_en  = 1'b0;
    nxt_en  = 1'b0;
    ptr_en  = 1'b0;
    rem_en  = 1'b0;
    data_en = 1'b0;
    mode_en = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_CHECK;
          cur_d   = start_addr_i;
          cur_en  = 1'b1;
          mode_en = 1'b1;
        end
      end
      ST_CHECK: state_d = cur_q[END_BIT] ? ST_DONE : ST_HREQ;
      ST_HREQ:  state_d = ST_HDAT;
      ST_HDAT: begin
        nxt_d  = mem_rdata_i[AW-1:0];
        nxt_en = 1'b1;
        rem_d  = len_o;
        rem_en = 1'b1;
        ptr_d  = cur_q[MB-1:2] + 1'b1;
        ptr_en = 1'b1;
        state_d = (len_o != '0) ? ST_PREQ : ST_LINK;
      end
      ST_PREQ: state_d = ST_PDAT;
      ST_PDAT: begin
        data_en = 1'b1;
        state_d = ST_PSEND;
      end
      ST_PSEND: begin
        if (cmd_ready_i) begin
          if (rem_q == LW'(1)) begin
            state_d = ST_LINK;
          end else begin
            state_d = ST_PREQ;
            rem_d   = rem_q - 1'b1;
            rem_en  = 1'b1;
            ptr_d   = ptr_q + 1'b1;
            ptr_en  = 1'b1;
          end
        end
      end
      ST_LINK: begin
        cur_d   = nxt_q;
        cur_en  = 1'b1;
        state_d = stop ? ST_DONE : ST_CHECK;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      nxt_q  <= '0;
      ptr_q  <= '0;
      rem_q  <= '0;
      data_q <= '0;
      ben_q  <= 1'b0;
      dbl_q  <= 1'b0;
    end else begin
      if (cur_en)  cur_q  <= cur_d;
      if (nxt_en)  nxt_q  <= nxt_d;
      if (ptr_en)  ptr_q  <= ptr_d;
      if (rem_en)  rem_q  <= rem_d;
      if (data_en) data_q <= data_d;
      if (mode_en) begin
        ben_q <= budget_en_i;
        dbl_q <= dbl_height_i;
      end
    end
  end

  assign mem_rd_o    = (state_q == ST_HREQ) || (state_q == ST_PREQ);
  assign mem_idx_o   = (state_q == ST_PREQ) ? ptr_q : cur_q[MB-1:2];
  assign cmd_valid_o = (state_q == ST_PSEND);
  assign cmd_data_o  = data_q;
  assign busy_o      = !idle_like;
  assign done_o      = (state_q == ST_DONE);
  assign cur_o       = cur_q;
  assign hdr_o       = (state_q == ST_HDAT);
  assign link_o      = (state_q == ST_LINK);
  assign step_o      = link_o && !stop;
  assign extra_en_o  = ben_q && dbl_q;
  assign nxt_o       = nxt_q;
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
  parameter int AW        = 24,
  parameter int DW        = 32,
  parameter int LW        = 8,
  parameter int CW        = 32,
  parameter int NW        = 32,
  parameter int MB        = 21,
  parameter int NODE_COST = 10,
  parameter int PAY_COST  = 5,
  parameter int DBL_COST  = 5,
  parameter int BUDGET    = 512,
  parameter int LIM_INIT  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          budget_en_i,
  input  logic          dbl_height_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] final_addr_o,
  output logic [CW-1:0] cycles_o,
  output logic          mem_rd_o,
  output logic [MB-3:0] mem_idx_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          cmd_valid_o,
  output logic [DW-1:0] cmd_data_o,
  input  logic          cmd_ready_i
);
  logic          over, hit, init, hdr, link, step, extra_en;
  logic [LW-1:0] len;
  logic [AW-1:0] nxt;

  dcw_walk_ctrl #(.AW(AW), .DW(DW), .LW(LW), .MB(MB)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .start_addr_i(start_addr_i),
    .budget_en_i(budget_en_i), .dbl_height_i(dbl_height_i),
    .over_i(over), .hit_i(hit),
    .mem_rd_o(mem_rd_o), .mem_idx_o(mem_idx_o), .mem_rdata_i(mem_rdata_i),
    .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_ready_i(cmd_ready_i),
    .busy_o(busy_o), .done_o(done_o), .cur_o(final_addr_o),
    .init_o(init), .hdr_o(hdr), .len_o(len), .link_o(link), .step_o(step),
    .extra_en_o(extra_en), .nxt_o(nxt)
  );

  dcw_cost_acc #(.CW(CW), .LW(LW), .NODE_COST(NODE_COST), .PAY_COST(PAY_COST),
                 .DBL_COST(DBL_COST), .BUDGET(BUDGET)) u_cost (
    .clk(clk), .rst_n(rst_n), .init_i(init), .hdr_i(hdr), .len_i(len),
    .link_i(link), .extra_en_i(extra_en), .cyc_o(cycles_o), .over_o(over)
  );

  dcw_loop_guard #(.AW(AW), .NW(NW), .LIM_INIT(LIM_INIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .init_i(init), .init_addr_i(start_addr_i),
    .step_i(step), .nxt_i(nxt), .hit_o(hit)
  );
endmodule

// File: rtl/dcw_checker.sv
module dcw_checker #(
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] final_addr_o,
  input logic [CW-1:0] cycles_o,
  input logic          mem_rd_o,
  input logic          cmd_valid_o,
  input logic [DW-1:0] cmd_data_o,
  input logic          cmd_ready_i
);
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o));

  p_done_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(final_addr_o) && $stable(cycles_o));

  p_start_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o);

  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  p_rd_not_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && cmd_valid_o));

  p_cost_grows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> cycles_o >= $past(cycles_o));
endmodule

bind dma_chain_walker dcw_checker #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .final_addr_o(final_addr_o), .cycles_o(cycles_o), .mem_rd_o(mem_rd_o),
  .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .cmd_ready_i(cmd_ready_i)
);

// File: tb/sim_dma_chain_walker.sv
`timescale 1ns/1ps
module sim_dma_chain_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] start_addr;
  logic        budget_en, dbl_h;
  logic        busy, done;
  logic [23:0] final_addr;
  logic [31:0] cycles;
  logic        mem_rd;
  logic [18:0] mem_idx;
  logic [31:0] mem_rdata;
  logic        cmd_valid;
  logic [31:0] cmd_data;
  logic        cmd_ready;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  logic [23:0] exp_final;
  int unsigned exp_cyc;
  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dma_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .budget_en_i(budget_en), .dbl_height_i(dbl_h), .busy_o(busy), .done_o(done),
    .final_addr_o(final_addr), .cycles_o(cycles), .mem_rd_o(mem_rd),
    .mem_idx_o(mem_idx), .mem_rdata_i(mem_rdata), .cmd_valid_o(cmd_valid),
    .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready)
  );

  // memory model: one-cycle read latency (R2)
  initial begin
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_rd) mem_rdata <= mem[mem_idx[9:0]];
    end
  end

  // sink with random back-pressure
  initial begin
    cmd_ready = 1'b0;
    forever begin
      @(negedge clk);
      cmd_ready = ($urandom % 4) != 0;
      #1;
      if (rst_n && cmd_valid && cmd_ready) got_q.push_back(cmd_data);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_node(input int w, input logic [7:0] len, input logic [23:0] nxt);
    mem[w & 1023] = {len, nxt};
    for (int i = 0; i < int'(len); i++) mem[(w + 1 + i) & 1023] = $urandom;
  endtask

  // reference walk computed from the requirements
  task automatic model(input logic [23:0] st, input bit ben, input bit dbl);
    logic [23:0] addr, ck;
    logic [18:0] idx, p;
    logic [31:0] h;
    int unsigned lim, cnt, cyc, len;
    exp_q.delete();
    addr = st; ck = st; lim = 32; cnt = 0; cyc = 0;
    for (int it = 0; it < 5000 && !addr[23]; it++) begin
      idx  = addr[20:2];
      h    = mem[idx[9:0]];
      len  = h[31:24];
      addr = h[23:0];
      cyc += 10;
      if (len != 0) cyc += 5 + len;
      for (int i = 0; i < int'(len); i++) begin
        p = idx + 19'(1 + i);
        exp_q.push_back(mem[p[9:0]]);
      end
      if (ben) begin
        if (dbl) cyc += 5;
        if (cyc > 512) break;
      end
      if (addr == ck) break;
      if (cnt == lim) begin ck = addr; lim = lim * 2; end
      cnt++;
    end
    exp_final = addr;
    exp_cyc   = cyc;
  endtask

  task automatic run(input logic [23:0] st, input bit ben, input bit dbl,
                     input string req, input bit poke);
    model(st, ben, dbl);
    got_q.delete();
    @(negedge clk);
    start_addr = st; budget_en = ben; dbl_h = dbl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: a second start while busy, with other mode bits, must be ignored
      repeat (3) @(negedge clk);
      start_addr = st ^ 24'h000040; budget_en = ~ben; dbl_h = ~dbl; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(got_q.size() == exp_q.size(), "R1", "payload count",
        got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], "R1", "payload word", got_q[i], exp_q[i]);
    chk(final_addr == exp_final, req, "final address", final_addr, exp_final);
    chk(cycles == exp_cyc, "R5", "cost", cycles, exp_cyc);
    repeat (4) @(negedge clk);
    chk(done && final_addr == exp_final && cycles == exp_cyc, "R9",
        "results held while done", {final_addr, cycles}, {exp_final, exp_cyc});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rst_n = 1'b0; start = 1'b0; start_addr = '0; budget_en = 1'b0; dbl_h = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !cmd_valid && !mem_rd, "R10", "reset state",
        {busy, done, cmd_valid, mem_rd}, 0);

    // R3: end marker at the start address
    run(24'h800010, 1'b0, 1'b0, "R3", 1'b0);

    // R4: zero-length middle node, with an ignored start while busy
    put_node(100, 8'd2, 24'(200 * 4));
    put_node(200, 8'd0, 24'(300 * 4));
    put_node(300, 8'd3, 24'h8ABCDE);
    run(24'(100 * 4), 1'b0, 1'b0, "R4", 1'b1);

    // R6: loop back to the start node
    put_node(400, 8'd1, 24'(500 * 4));
    put_node(500, 8'd0, 24'(400 * 4));
    run(24'(400 * 4), 1'b0, 1'b0, "R6", 1'b0);

    // R6: loop that misses the start node, caught after the checkpoint moves
    put_node(600, 8'd0, 24'(620 * 4));
    put_node(620, 8'd0, 24'(640 * 4));
    put_node(640, 8'd0, 24'(660 * 4));
    put_node(660, 8'd0, 24'(620 * 4));
    run(24'(600 * 4), 1'b0, 1'b0, "R6", 1'b0);

    // R7: budget cut-off with and without double height, and no budget
    for (int k = 0; k < 20; k++)
      put_node(16 * k, 8'd15, (k == 19) ? 24'h800123 : 24'(16 * (k + 1) * 4));
    run(24'h0, 1'b1, 1'b1, "R7", 1'b0);
    run(24'h0, 1'b1, 1'b0, "R7", 1'b0);
    run(24'h0, 1'b0, 1'b1, "R7", 1'b0);

    // R2: address bits 22:21 and 1:0 alias to the same word
    put_node(700, 8'd1, 24'h800777);
    run(24'h600000 | 24'(700 * 4) | 24'h3, 1'b0, 1'b0, "R2", 1'b0);

    // random chains, some closing into loops
    for (int t = 0; t < 40; t++) begin
      int n, r, j;
      logic [23:0] nx, hi;
      n = 1 + int'($urandom % 12);
      r = int'($urandom % 60);
      for (int k = 0; k < n; k++) begin
        hi = {1'b0, 2'($urandom), 21'h0};
        if (k < n - 1) begin
          nx = hi | 24'(((((k + 1) * 7 + r) % 60) * 16) * 4);
        end else if (($urandom % 10) < 7) begin
          nx = 24'h800000 | 24'($urandom % 24'h7FFFFF);
        end else begin
          j  = int'($urandom % n);
          nx = 24'((((j * 7 + r) % 60) * 16) * 4);
        end
        put_node(((k * 7 + r) % 60) * 16, 8'($urandom % 16), nx);
      end
      run(24'((((r) % 60) * 16) * 4), 1'($urandom), 1'($urandom), "R6", 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule